// File: doc/BRIEF.md
# Bresenham line drawing engine

This block walks a straight line one coordinate per clock using an error-term stepper. The host sets up a start position, a signed error term, an axial and a diagonal step constant and a major-axis pixel count. The host works out the error term and both constants in advance, so the engine only adds and compares. A command word then starts the line. It selects the octant with three separate bits: X direction, Y direction, and which axis is major. It can also leave out the final pixel, or move the position without emitting any pixels.

While drawing, the engine offers each pixel coordinate on a valid/ready output and advances on every accepted handshake. At most one pixel is produced per cycle. `busy` is high for the whole operation. When the engine returns to idle, the position registers hold the coordinate that follows the last pixel processed. A later command can therefore continue from there without reloading the start point.

Control is one state machine with four states. ST_IDLE waits for a command. ST_DRAW emits pixels. ST_MOVE steps silently. ST_DONE covers a command that asks for zero pixels. The transitions are:
- START_DRAW: ST_IDLE to ST_DRAW.
- START_MOVE: ST_IDLE to ST_MOVE.
- START_EMPTY: ST_IDLE to ST_DONE.
- DRAW_END: ST_DRAW to ST_IDLE, on the handshake of the last pixel.
- MOVE_END: ST_MOVE to ST_IDLE, after the last step.
- EMPTY_END: ST_DONE to ST_IDLE, after one cycle.

Top module: `bres_line_engine`

## Requirements
- R1: After reset, `busy` and `pix_valid` are 0, and `pos_x`, `pos_y`, the error term, both step constants and the count are all 0.
- R2: A host write (`cfg_we`) stores the low bits of `cfg_wdata` into the register chosen by `cfg_addr`:
  - 0 is X position (11 bits).
  - 1 is Y position (11 bits).
  - 2 is the signed error term (14 bits).
  - 3 is the signed axial step (14 bits).
  - 4 is the signed diagonal step (14 bits).
  - 5 is the pixel count (12 bits).
  - Higher bits of `cfg_wdata` are dropped.
  - Writes made while `busy` is high have no effect.
- R3: A command starts only when `cmd_word[15:12]` equals 4'h2 and `busy` is low. Any other opcode, including 4'h0, and any command written while busy leave the engine unchanged.
- R4: `cmd_word` bits 5, 7 and 6 set the stepping:
  - Bit 5 set steps X by +1; clear steps X by -1.
  - Bit 7 set steps Y by +1; clear steps Y by -1.
  - Bit 6 set makes Y the major axis; clear makes X the major axis.
- R5: Each step moves the major axis by one. If the error term is non-negative, the minor axis also moves by one and the diagonal step is added to the error term; otherwise the axial step is added.
- R6: A command produces count+1 steps. When `cmd_word` bit 2 is set it produces exactly count steps, so a count of 0 with bit 2 set produces none.
- R7: With `cmd_word` bit 4 set, each step is offered as a pixel on `pix_valid`/`pix_x`/`pix_y`, one pixel per cycle while `pix_ready` is high. With bit 4 clear, the engine takes one step per cycle and `pix_valid` stays 0.
- R8: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_x` and `pix_y` hold their values.
- R9: `busy` is high in the cycle after a command is accepted. It stays high until the final step: the last pixel handshake, or the last silent step. For a zero-step command it is high for exactly one cycle.
- R10: On return to idle, `pos_x`/`pos_y` hold the coordinate after the last pixel processed. A following command without reloaded coordinates continues from there.
- R11: Coordinates wrap modulo 2048, so stepping +1 from 2047 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Host register write strobe |
| cfg_addr | input | 3 | Host register select |
| cfg_wdata | input | 16 | Host register write data |
| cmd_we | input | 1 | Command write strobe |
| cmd_word | input | 16 | Command word (opcode and flags) |
| pix_ready | input | 1 | Downstream accepts the offered pixel |
| pix_valid | output | 1 | A pixel coordinate is offered |
| pix_x | output | 11 | Offered pixel X |
| pix_y | output | 11 | Offered pixel Y |
| pos_x | output | 11 | Current X position |
| pos_y | output | 11 | Current Y position |
| busy | output | 1 | Operation in progress |

## Verification
The bench targets the following corner cases:
- Steps in all directions and both major axes. A swapped or inverted direction bit would walk away from the expected endpoint.
- A line that crosses 2047, where a missing wrap shows up as a wrong coordinate.
- Dropping the last pixel, and a zero count with the drop bit set. An off-by-one in the step total shows up there as an extra or missing pixel, or a busy pulse of the wrong length.
- A stalled `pix_ready` pattern. It exposes a design that advances without a handshake or changes coordinates under stall.
- Commands and position writes made mid-line. A design that fails to ignore them bends the path or restarts it.
- A silent move, which must end at the right position with no pixel offered.

// File: rtl/bres_pkg.sv
package bres_pkg;

    localparam int CMD_W         = 16;
    localparam int OP_LSB        = 12;
    localparam int BIT_Y_INC     = 7;
    localparam int BIT_Y_MAJOR   = 6;
    localparam int BIT_X_INC     = 5;
    localparam int BIT_DRAW      = 4;
    localparam int BIT_SKIP_LAST = 2;

    localparam logic [3:0] OP_NOP  = 4'h0;
    localparam logic [3:0] OP_LINE = 4'h2;

    typedef enum logic [2:0] {
        SEL_X     = 3'd0,
        SEL_Y     = 3'd1,
        SEL_ERR   = 3'd2,
        SEL_AXIAL = 3'd3,
        SEL_DIAG  = 3'd4,
        SEL_COUNT = 3'd5
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DRAW = 2'd1,
        ST_MOVE = 2'd2,
        ST_DONE = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic y_inc;
        logic y_major;
        logic x_inc;
        logic draw;
        logic skip_last;
    } line_flags_t;

    function automatic line_flags_t decode_flags(input logic [CMD_W-1:0] w);
        line_flags_t f;
        f.y_inc     = w[BIT_Y_INC];
        f.y_major   = w[BIT_Y_MAJOR];
        f.x_inc     = w[BIT_X_INC];
        f.draw      = w[BIT_DRAW];
        f.skip_last = w[BIT_SKIP_LAST];
        return f;
    endfunction

endpackage

// File: rtl/bres_constregs.sv
module bres_constregs
    import bres_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ERR_W  = 14,
    parameter int CNT_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  cfg_sel_e                sel,
    input  logic [DATA_W-1:0]       wdata,
    output logic signed [ERR_W-1:0] axial,
    output logic signed [ERR_W-1:0] diag,
    output logic [CNT_W-1:0]        count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            axial <= '0;
            diag  <= '0;
            count <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_AXIAL: axial <= wdata[ERR_W-1:0];
                SEL_DIAG:  diag  <= wdata[ERR_W-1:0];
                SEL_COUNT: count <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bres_stepper.sv
module bres_stepper
    import bres_pkg::*;
#(
    parameter int COORD_W = 11,
    parameter int ERR_W   = 14
) (
    input  logic [COORD_W-1:0]      cur_x,
    input  logic [COORD_W-1:0]      cur_y,
    input  logic signed [ERR_W-1:0] err,
    input  logic signed [ERR_W-1:0] axial,
    input  logic signed [ERR_W-1:0] diag,
    input  line_flags_t             flags,
    output logic [COORD_W-1:0]      nxt_x,
    output logic [COORD_W-1:0]      nxt_y,
    output logic signed [ERR_W-1:0] nxt_err
);

    localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

    logic                minor_go;
    logic [COORD_W-1:0]  x_moved;
    logic [COORD_W-1:0]  y_moved;

    always_comb begin
        minor_go = ~err[ERR_W-1];
        x_moved  = flags.x_inc ? (cur_x + ONE) : (cur_x - ONE);
        y_moved  = flags.y_inc ? (cur_y + ONE) : (cur_y - ONE);
        nxt_err  = minor_go ? (err + diag) : (err + axial);
        if (flags.y_major) begin
            nxt_y = y_moved;
            nxt_x = minor_go ? x_moved : cur_x;
        end else begin
            nxt_x = x_moved;
            nxt_y = minor_go ? y_moved : cur_y;
        end
    end

endmodule

// File: rtl/bres_position.sv
module bres_position
    import bres_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int COORD_W = 11,
    parameter int ERR_W   = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  cfg_sel_e                sel,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    step_en,
    input  logic [COORD_W-1:0]      nxt_x,
    input  logic [COORD_W-1:0]      nxt_y,
    input  logic signed [ERR_W-1:0] nxt_err,
    output logic [COORD_W-1:0]      cur_x,
    output logic [COORD_W-1:0]      cur_y,
    output logic signed [ERR_W-1:0] err
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x <= '0;
            cur_y <= '0;
            err   <= '0;
        end else if (step_en) begin
            cur_x <= nxt_x;
            cur_y <= nxt_y;
            err   <= nxt_err;
        end else if (wr_en) begin
            case (sel)
                SEL_X:   cur_x <= wdata[COORD_W-1:0];
                SEL_Y:   cur_y <= wdata[COORD_W-1:0];
                SEL_ERR: err   <= wdata[ERR_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bres_ctrl.sv
module bres_ctrl
    import bres_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_go,
    input  line_flags_t      cmd_flags,
    input  logic [CNT_W-1:0] count,
    input  logic             pix_ready,
    output logic             busy,
    output logic             pix_valid,
    output logic             step_en,
    output line_flags_t      run_flags
);

    localparam int REM_W = CNT_W + 1;
    localparam logic [REM_W-1:0] REM_ONE = REM_W'(1);

    eng_state_e       state_q;
    eng_state_e       state_d;
    logic [REM_W-1:0] rem_q;
    logic [REM_W-1:0] total;
    logic             last_step;
    logic             accept;

    always_comb begin
        total     = {1'b0, count} + {{CNT_W{1'b0}}, ~cmd_flags.skip_last};
        last_step = (rem_q == REM_ONE);
        accept    = (state_q == ST_IDLE) && cmd_go;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_go) begin
                    if (total == '0)         state_d = ST_DONE;  // START_EMPTY
                    else if (cmd_flags.draw) state_d = ST_DRAW;  // START_DRAW
                    else                     state_d = ST_MOVE;  // START_MOVE
                end
            end
            ST_DRAW: if (pix_ready && last_step) state_d = ST_IDLE; // DRAW_END
            ST_MOVE: if (last_step)              state_d = ST_IDLE; // MOVE_END
            ST_DONE:                             state_d = ST_IDLE; // EMPTY_END
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // remaining-step counter and latched flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q     <= '0;
            run_flags <= '0;
        end else if (accept) begin
            rem_q     <= total;
            run_flags <= cmd_flags;
        end else if (step_en) begin
            rem_q <= rem_q - REM_ONE;
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        pix_valid = 1'b0;
        step_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DRAW: begin
                busy      = 1'b1;
                pix_valid = 1'b1;
                step_en   = pix_ready;
            end
            ST_MOVE: begin
                busy    = 1'b1;
                step_en = 1'b1;
            end
            ST_DONE: busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/bres_line_engine.sv
module bres_line_engine
    import bres_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int COORD_W = 11,
    parameter int ERR_W   = 14,
    parameter int CNT_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic               cmd_we,
    input  logic [CMD_W-1:0]   cmd_word,
    input  logic               pix_ready,
    output logic               pix_valid,
    output logic [COORD_W-1:0] pix_x,
    output logic [COORD_W-1:0] pix_y,
    output logic [COORD_W-1:0] pos_x,
    output logic [COORD_W-1:0] pos_y,
    output logic               busy
);

    cfg_sel_e                sel;
    logic                    host_wr;
    logic                    cmd_go;
    line_flags_t             cmd_flags;
    line_flags_t             run_flags;
    logic                    step_en;
    logic signed [ERR_W-1:0] axial;
    logic signed [ERR_W-1:0] diag;
    logic [CNT_W-1:0]        count;
    logic signed [ERR_W-1:0] err;
    logic signed [ERR_W-1:0] nxt_err;
    logic [COORD_W-1:0]      cur_x;
    logic [COORD_W-1:0]      cur_y;
    logic [COORD_W-1:0]      nxt_x;
    logic [COORD_W-1:0]      nxt_y;

    always_comb begin
        sel       = cfg_sel_e'(cfg_addr);
        host_wr   = cfg_we && !busy;
        cmd_go    = cmd_we && (cmd_word[OP_LSB+3:OP_LSB] == OP_LINE);
        cmd_flags = decode_flags(cmd_word);
    end

    bres_constregs #(.DATA_W(DATA_W), .ERR_W(ERR_W), .CNT_W(CNT_W)) u_const (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (host_wr),
        .sel   (sel),
        .wdata (cfg_wdata),
        .axial (axial),
        .diag  (diag),
        .count (count)
    );

    bres_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_go    (cmd_go),
        .cmd_flags (cmd_flags),
        .count     (count),
        .pix_ready (pix_ready),
        .busy      (busy),
        .pix_valid (pix_valid),
        .step_en   (step_en),
        .run_flags (run_flags)
    );

    bres_stepper #(.COORD_W(COORD_W), .ERR_W(ERR_W)) u_step (
        .cur_x   (cur_x),
        .cur_y   (cur_y),
        .err     (err),
        .axial   (axial),
        .diag    (diag),
        .flags   (run_flags),
        .nxt_x   (nxt_x),
        .nxt_y   (nxt_y),
        .nxt_err (nxt_err)
    );

    bres_position #(.DATA_W(DATA_W), .COORD_W(COORD_W), .ERR_W(ERR_W)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr),
        .sel     (sel),
        .wdata   (cfg_wdata),
        .step_en (step_en),
        .nxt_x   (nxt_x),
        .nxt_y   (nxt_y),
        .nxt_err (nxt_err),
        .cur_x   (cur_x),
        .cur_y   (cur_y),
        .err     (err)
    );

    always_comb begin
        pix_x = cur_x;
        pix_y = cur_y;
        pos_x = cur_x;
        pos_y = cur_y;
    end

endmodule

// File: rtl/bres_line_engine_chk.sv
module bres_line_engine_chk #(
    parameter int COORD_W = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_we,
    input logic [15:0]        cmd_word,
    input logic               pix_ready,
    input logic               pix_valid,
    input logic [COORD_W-1:0] pix_x,
    input logic [COORD_W-1:0] pix_y,
    input logic [COORD_W-1:0] pos_x,
    input logic [COORD_W-1:0] pos_y,
    input logic               busy
);

    AST_LINE_CMD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_we && cmd_word[15:12] == 4'h2) |=> busy); // R3

    AST_OTHER_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_we && cmd_word[15:12] != 4'h2) |=> !busy); // R3

    AST_MAJOR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready) |=> (pos_x != $past(pos_x)) || (pos_y != $past(pos_y))); // R5

    AST_MOVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_we && cmd_word[15:12] == 4'h2 && !cmd_word[4]) |=> !pix_valid); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_x) && $stable(pix_y))); // R8

    AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> busy); // R9

endmodule

bind bres_line_engine bres_line_engine_chk #(.COORD_W(COORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_word  (cmd_word),
    .pix_ready (pix_ready),
    .pix_valid (pix_valid),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .pos_x     (pos_x),
    .pos_y     (pos_y),
    .busy      (busy)
);

// File: tb/bres_line_engine_tb.sv
module bres_line_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        pix_ready = 1'b0;
    logic        pix_valid;
    logic [10:0] pix_x, pix_y, pos_x, pos_y;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    bres_line_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cmd_we(cmd_we), .cmd_word(cmd_word),
        .pix_ready(pix_ready), .pix_valid(pix_valid), .pix_x(pix_x),
        .pix_y(pix_y), .pos_x(pos_x), .pos_y(pos_y), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [2:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic run_line(input int x0, input int y0, input int e0, input int ax,
                            input int dg, input int cnt, input logic [15:0] cmd,
                            input bit load_xy, input bit stall, input bit interfere,
                            input string req, input int endx, input int endy);
        int mx, my, me, n, got, busy_cyc, guard, lastx, lasty, hx, hy;
        bit xinc, yinc, ymaj, drw, skip, held;
        if (load_xy) begin
            wr_cfg(3'd0, 16'(x0));
            wr_cfg(3'd1, 16'(y0));
        end
        wr_cfg(3'd2, 16'(e0));
        wr_cfg(3'd3, 16'(ax));
        wr_cfg(3'd4, 16'(dg));
        wr_cfg(3'd5, 16'(cnt));
        mx = load_xy ? x0 : int'(pos_x);
        my = load_xy ? y0 : int'(pos_y);
        me = e0;
        xinc = cmd[5]; yinc = cmd[7]; ymaj = cmd[6]; drw = cmd[4]; skip = cmd[2];
        n = skip ? cnt : cnt + 1;
        lastx = -1; lasty = -1; held = 0; hx = 0; hy = 0;
        cmd_we = 1'b1; cmd_word = cmd;
        tick();
        cmd_we = 1'b0;
        chk(busy == 1'b1, {req, " R9 busy after accept"}, int'(busy), 1);
        got = 0; busy_cyc = 0; guard = 0;
        while (busy && guard < 5000) begin
            guard++;
            busy_cyc++;
            if (interfere && guard == 2) begin
                cmd_we = 1'b1; cmd_word = 16'h20F0;
                cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 16'd999;
            end else begin
                cmd_we = 1'b0; cfg_we = 1'b0;
            end
            pix_ready = stall ? (guard % 3 != 1) : 1'b1;
            #1;
            if (held) begin
                chk(pix_valid && pix_x == 11'(hx) && pix_y == 11'(hy), {req, " R8 held under stall"},
                    int'(pix_x) * 4096 + int'(pix_y), hx * 4096 + hy);
                held = 0;
            end
            if (!drw) chk(!pix_valid, {req, " R7 move offers no pixel"}, int'(pix_valid), 0);
            if (pix_valid && !pix_ready) begin
                held = 1; hx = int'(pix_x); hy = int'(pix_y);
            end
            if ((pix_valid && pix_ready) || (!drw && n > 0)) begin
                if (drw) begin
                    chk(int'(pix_x) == mx && int'(pix_y) == my, {req, " R5 pixel"},
                        int'(pix_x) * 4096 + int'(pix_y), mx * 4096 + my);
                    got++;
                end
                lastx = mx; lasty = my;
                if (ymaj) begin
                    my = (my + (yinc ? 1 : -1)) & 2047;
                    if (me >= 0) begin mx = (mx + (xinc ? 1 : -1)) & 2047; me = me + dg; end
                    else me = me + ax;
                end else begin
                    mx = (mx + (xinc ? 1 : -1)) & 2047;
                    if (me >= 0) begin my = (my + (yinc ? 1 : -1)) & 2047; me = me + dg; end
                    else me = me + ax;
                end
            end
            @(posedge clk);
            @(negedge clk);
        end
        cmd_we = 1'b0; cfg_we = 1'b0; pix_ready = 1'b0;
        chk(guard < 5000, {req, " R9 busy ends"}, guard, 0);
        chk(got == (drw ? n : 0), {req, " R6 pixel total"}, got, drw ? n : 0);
        if (!stall)
            chk(busy_cyc == ((n == 0) ? 1 : n), {req, " R9 busy length"}, busy_cyc, (n == 0) ? 1 : n);
        #1;
        chk(!pix_valid && !busy, {req, " R9 idle after end"}, int'(busy), 0);
        chk(int'(pos_x) == mx && int'(pos_y) == my, {req, " R10 final position"},
            int'(pos_x) * 4096 + int'(pos_y), mx * 4096 + my);
        if (endx >= 0)
            chk(lastx == endx && lasty == endy, {req, " R5 endpoint"},
                lastx * 4096 + lasty, endx * 4096 + endy);
    endtask

    task automatic t_reset();
        chk(!busy, "R1 busy at reset", int'(busy), 0);
        chk(!pix_valid, "R1 valid at reset", int'(pix_valid), 0);
        chk(pos_x == 0 && pos_y == 0, "R1 position at reset", int'(pos_x) + int'(pos_y), 0);
    endtask

    task automatic t_mask();
        wr_cfg(3'd0, 16'hFFFF);
        chk(pos_x == 11'h7FF, "R2 X write masked", int'(pos_x), 2047);
        wr_cfg(3'd1, 16'hF805);
        chk(pos_y == 11'h005, "R2 Y write masked", int'(pos_y), 5);
    endtask

    task automatic t_ignored_ops();
        logic [10:0] sx, sy;
        wr_cfg(3'd5, 16'd4);
        sx = pos_x; sy = pos_y;
        cmd_we = 1'b1; cmd_word = 16'h0030;
        tick();
        chk(!busy, "R3 no-op opcode ignored", int'(busy), 0);
        cmd_word = 16'h6030;
        tick();
        cmd_we = 1'b0;
        chk(!busy, "R3 foreign opcode ignored", int'(busy), 0);
        tick();
        chk(!pix_valid && pos_x == sx && pos_y == sy, "R3 position untouched",
            int'(pos_x), int'(sx));
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_mask();
        // R4 R5 X-major, +X +Y: (10,20) to (18,23)
        run_line(10, 20, -2, 6, -10, 8, 16'h20B0, 1, 0, 0, "R4 xmajor", 18, 23);
        // R10 continue from previous end without reloading position
        run_line(0, 0, -2, 6, -10, 8, 16'h20B0, 0, 0, 0, "R10 continue", 27, 26);
        // R4 Y-major, -X -Y: (100,200) to (96,190)
        run_line(100, 200, -2, 8, -12, 10, 16'h2050, 1, 0, 0, "R4 ymajor neg", 96, 190);
        // R6 R8 last pixel dropped under stall: 45 degrees +X -Y
        run_line(50, 50, 6, 12, 0, 6, 16'h2034, 1, 1, 0, "R6 skip last", 55, 45);
        // R7 silent move, Y-major +X +Y
        run_line(300, 300, 3, 10, -4, 7, 16'h20E0, 1, 0, 0, "R7 move", -1, -1);
        // R11 wrap through 2047
        run_line(2046, 7, -4, 0, -8, 4, 16'h2030, 1, 0, 0, "R11 wrap", 2, 7);
        // R6 zero steps
        run_line(40, 40, 0, 0, 0, 0, 16'h2014, 1, 0, 0, "R6 zero count", -1, -1);
        // R2 R3 writes and commands while busy ignored
        run_line(0, 0, -1, 2, -2, 12, 16'h20A0, 1, 0, 1, "R3 busy ignores", -1, -1);
        t_ignored_ops();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule